// File: doc/BRIEF.md
# Handle Hash Table Engine

This block keeps a table of object handles in on-chip RAM and serves insert, lookup and remove commands. Each table slot holds two 32-bit words: the handle itself and a context word. The context word packs a channel number, an engine code and a 16-bit instance pointer. A command arrives on a valid/ready request port. The engine computes a start slot from the handle and channel, then probes the table linearly, one slot at a time, wrapping from the last slot to slot zero. It finishes with a one-cycle done pulse that carries a status code, a slot index and, for a hit, the stored context word.

The table holds 2^HB slots, where HB is a build parameter from 9 to 12. Both words of a slot are read in a single RAM access, and each probe takes exactly two cycles. A slot counts as empty only when both of its words are zero. After reset the engine clears the whole table before it accepts any command. Two context layouts are supported, and a per-command format input selects between them. Only one command is handled at a time.

Top module: `hht_engine`

## Requirements
- R1: After reset is released, req_ready stays low for exactly 2^HB clock cycles while every slot is cleared. After that, every lookup misses.
- R2: The start slot is found as follows. Begin with a sum of zero. XOR into it each successive HB-bit chunk of the handle, least significant chunk first, until all 32 bits are used. Then XOR in the channel shifted left by HB-4. The start slot is this result modulo 2^HB.
- R3: With req_fmt=0 (legacy layout), the stored context word has bit 31 set, the channel in bits 28:24, the engine code in bits 17:16 and instance address bits 19:4 in bits 15:0. All other bits are zero.
- R4: With req_fmt=1 (compact layout), the stored context word has no valid bit, the channel in bits 27:23, the engine code in bits 21:20 and instance address bits 19:4 in bits 15:0. All other bits are zero.
- R5: An insert probes from the start slot. A slot whose handle word or context word is nonzero is occupied, and the probe moves on by one slot, wrapping from slot 2^HB-1 to slot 0. The entry is written into the first empty slot, with status OK (0) and that slot's index.
- R6: If an insert's probe returns to its start slot, the insert ends with status FULL (2), reports the start slot, and writes nothing.
- R7: An insert that meets a slot holding the same handle, a nonzero context word and the same channel field (decoded in the layout given by req_fmt) ends with status DUP (1) and that slot's index. It writes nothing.
- R8: A lookup follows the same probe order. On a slot matching as in R7, it ends with status HIT (3), the slot index and the stored context word. On an empty slot, or after a full wrap, it ends with status MISS (4), the start slot and a zero context word.
- R9: A remove (op 2) writes zero to both words of slot req_slot. It ends with status OK and slot req_slot, after which that slot reads as empty.
- R10: req_ready is high only when the engine is idle. An insert or lookup raises done exactly 2×(number of slots probed) cycles after the accepting edge. A remove raises done 1 cycle after it. Done lasts a single cycle.
- R11: Opcode 3 touches no slot and ends 1 cycle after acceptance with status BADOP (5) and slot 0. Opcodes: 0 insert, 1 lookup, 2 remove.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Engine idle and able to accept |
| req_op | input | 2 | 0 insert, 1 lookup, 2 remove, 3 unused |
| req_fmt | input | 1 | Context layout: 0 legacy, 1 compact |
| req_chan | input | 5 | Channel number |
| req_handle | input | 32 | Object handle |
| req_engine | input | 2 | Engine code |
| req_inst | input | 20 | Instance byte address |
| req_slot | input | HB | Slot to clear on remove |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 3 | 0 OK, 1 DUP, 2 FULL, 3 HIT, 4 MISS, 5 BADOP |
| done_slot | output | HB | Slot index for the result |
| done_ctx | output | 32 | Context word on a hit, else zero |

## Verification
On every cycle, the in-RTL assertions check the handshake and the pulse shape. They check that the engine goes busy after an accept, that done never lasts two cycles, that no probe command completes one cycle after acceptance, that a hit never returns an empty context word, and that a table-full result follows a cycle with no RAM write. Only the bench scenarios can show whether the hash lands where it should, whether the packed context layouts are correct, whether duplicates and wrap-around probing behave as required, and whether the table behaves correctly when completely full. The bench checks these against a shadow table computed arithmetically. It includes a sweep that fills every slot and then looks each one up.

// File: rtl/hht_pkg.sv
package hht_pkg;
  localparam int CHAN_W = 5;
  localparam int ENG_W  = 2;
  localparam int INST_W = 20;

  typedef enum logic [1:0] {
    OP_INSERT = 2'd0,
    OP_LOOKUP = 2'd1,
    OP_REMOVE = 2'd2,
    OP_SPARE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_OK    = 3'd0,
    ST_DUP   = 3'd1,
    ST_FULL  = 3'd2,
    ST_HIT   = 3'd3,
    ST_MISS  = 3'd4,
    ST_BADOP = 3'd5
  } status_e;

  // Build the context word in the selected layout.
  function automatic logic [31:0] pack_ctx(input logic fmt_new,
                                           input logic [CHAN_W-1:0] ch,
                                           input logic [ENG_W-1:0] eng,
                                           input logic [INST_W-1:0] inst);
    if (fmt_new)
      return {4'b0, ch, 1'b0, eng, 4'b0, inst[19:4]};
    else
      return {1'b1, 2'b0, ch, 6'b0, eng, inst[19:4]};
  endfunction

  // Recover the channel field of a stored context word.
  function automatic logic [CHAN_W-1:0] ctx_chan(input logic fmt_new,
                                                 input logic [31:0] w);
    return fmt_new ? w[27:23] : w[28:24];
  endfunction
endpackage

// File: rtl/hht_hash.sv
module hht_hash #(
  parameter int HB = 9
) (
  input  logic [31:0]  handle,
  input  logic [4:0]   chan,
  output logic [HB-1:0] slot
);
  localparam int NCHUNK = (32 + HB - 1) / HB;
  localparam int SH     = HB - 4;

  logic [HB-1:0] acc;
  logic [31:0]   rest;
  logic [HB:0]   chmix;

  always_comb begin
    acc  = '0;
    rest = handle;
    for (int i = 0; i < NCHUNK; i++) begin
      acc  = acc ^ rest[HB-1:0];
      rest = rest >> HB;
    end
    chmix = {{(HB-4){1'b0}}, chan} << SH;
    slot  = acc ^ chmix[HB-1:0];
  end
endmodule

// File: rtl/hht_ram.sv
module hht_ram #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hht_ctrl.sv
module hht_ctrl
  import hht_pkg::*;
#(
  parameter int HB = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic          req_fmt,
  input  logic [4:0]    req_chan,
  input  logic [31:0]   req_handle,
  input  logic [1:0]    req_engine,
  input  logic [19:0]   req_inst,
  input  logic [HB-1:0] req_slot,
  input  logic [HB-1:0] hash_slot,
  output logic [HB-1:0] rd_addr,
  input  logic [31:0]   rd_hdl,
  input  logic [31:0]   rd_ctx,
  output logic          wr_en,
  output logic [HB-1:0] wr_addr,
  output logic [31:0]   wr_hdl,
  output logic [31:0]   wr_ctx,
  output logic          done,
  output logic [2:0]    done_status,
  output logic [HB-1:0] done_slot,
  output logic [31:0]   done_ctx
);
  localparam logic [HB-1:0] LAST = {HB{1'b1}};

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_ADDR, S_EVAL, S_FIN} state_e;

  state_e        state;
  op_e           op_q;
  logic          fmt_q;
  logic [4:0]    chan_q;
  logic [31:0]   hdl_q;
  logic [31:0]   ctx_q;
  logic [HB-1:0] start_q, idx_q, slot_q, clr_q;

  // Evaluation of the slot just read
  logic          occ, match, wrapped;
  logic [HB-1:0] nxt;
  logic          ev_done;
  status_e       ev_status;
  logic [HB-1:0] ev_slot;
  logic [31:0]   ev_ctx;

  assign req_ready = (state == S_IDLE);
  assign rd_addr   = idx_q;

  always_comb begin
    occ     = (rd_hdl != '0) || (rd_ctx != '0);
    match   = (rd_hdl == hdl_q) && (rd_ctx != '0) &&
              (ctx_chan(fmt_q, rd_ctx) == chan_q);
    nxt     = idx_q + 1'b1;
    wrapped = (nxt == start_q);
    ev_done   = 1'b0;
    ev_status = ST_OK;
    ev_slot   = idx_q;
    ev_ctx    = '0;
    if (op_q == OP_INSERT) begin
      if (!occ) begin
        ev_done = 1'b1;
      end else if (match) begin
        ev_done = 1'b1; ev_status = ST_DUP;
      end else if (wrapped) begin
        ev_done = 1'b1; ev_status = ST_FULL; ev_slot = start_q;
      end
    end else begin
      if (!occ) begin
        ev_done = 1'b1; ev_status = ST_MISS; ev_slot = start_q;
      end else if (match) begin
        ev_done = 1'b1; ev_status = ST_HIT; ev_ctx = rd_ctx;
      end else if (wrapped) begin
        ev_done = 1'b1; ev_status = ST_MISS; ev_slot = start_q;
      end
    end
  end

  // RAM write port: clear sweep, insert into a free slot, or remove
  always_comb begin
    wr_en   = 1'b0;
    wr_addr = idx_q;
    wr_hdl  = '0;
    wr_ctx  = '0;
    case (state)
      S_INIT: begin
        wr_en = 1'b1; wr_addr = clr_q;
      end
      S_EVAL: if (op_q == OP_INSERT && !occ) begin
        wr_en = 1'b1; wr_hdl = hdl_q; wr_ctx = ctx_q;
      end
      S_FIN: if (op_q == OP_REMOVE) begin
        wr_en = 1'b1; wr_addr = slot_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_INIT;
      clr_q       <= '0;
      op_q        <= OP_INSERT;
      fmt_q       <= 1'b0;
      chan_q      <= '0;
      hdl_q       <= '0;
      ctx_q       <= '0;
      start_q     <= '0;
      idx_q       <= '0;
      slot_q      <= '0;
      done        <= 1'b0;
      done_status <= '0;
      done_slot   <= '0;
      done_ctx    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_INIT: begin
          clr_q <= clr_q + 1'b1;
          if (clr_q == LAST) state <= S_IDLE;
        end
        S_IDLE: if (req_valid) begin
          op_q    <= op_e'(req_op);
          fmt_q   <= req_fmt;
          chan_q  <= req_chan;
          hdl_q   <= req_handle;
          ctx_q   <= pack_ctx(req_fmt, req_chan, req_engine, req_inst);
          slot_q  <= req_slot;
          idx_q   <= hash_slot;
          start_q <= hash_slot;
          state   <= (req_op == OP_INSERT || req_op == OP_LOOKUP) ? S_ADDR : S_FIN;
        end
        S_ADDR: state <= S_EVAL;
        S_EVAL: begin
          if (ev_done) begin
            done        <= 1'b1;
            done_status <= ev_status;
            done_slot   <= ev_slot;
            done_ctx    <= ev_ctx;
            state       <= S_IDLE;
          end else begin
            idx_q <= nxt;
            state <= S_ADDR;
          end
        end
        S_FIN: begin
          done        <= 1'b1;
          done_status <= (op_q == OP_REMOVE) ? ST_OK : ST_BADOP;
          done_slot   <= (op_q == OP_REMOVE) ? slot_q : '0;
          done_ctx    <= '0;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R10
  probe_min_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_op == 2'd0 || req_op == 2'd1)) |=> !done);
  // R8
  hit_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_status == 3'd3) |-> (done_ctx != '0));
  // R6
  full_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_status == 3'd2) |-> !$past(wr_en));
endmodule

// File: rtl/hht_engine.sv
module hht_engine #(
  parameter int HB = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic          req_fmt,
  input  logic [4:0]    req_chan,
  input  logic [31:0]   req_handle,
  input  logic [1:0]    req_engine,
  input  logic [19:0]   req_inst,
  input  logic [HB-1:0] req_slot,
  output logic          done,
  output logic [2:0]    done_status,
  output logic [HB-1:0] done_slot,
  output logic [31:0]   done_ctx
);
  localparam int NBANK = 2;

  logic [HB-1:0] hash_slot;
  logic [HB-1:0] rd_addr, wr_addr;
  logic          wr_en;
  logic [31:0]   bank_wd [NBANK];
  logic [31:0]   bank_rd [NBANK];

  hht_hash #(.HB(HB)) u_hash (
    .handle (req_handle),
    .chan   (req_chan),
    .slot   (hash_slot)
  );

  // Bank 0 holds handle words, bank 1 holds context words.
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    hht_ram #(.AW(HB), .DW(32)) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (bank_wd[g]),
      .raddr (rd_addr),
      .rdata (bank_rd[g])
    );
  end

  hht_ctrl #(.HB(HB)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_fmt     (req_fmt),
    .req_chan    (req_chan),
    .req_handle  (req_handle),
    .req_engine  (req_engine),
    .req_inst    (req_inst),
    .req_slot    (req_slot),
    .hash_slot   (hash_slot),
    .rd_addr     (rd_addr),
    .rd_hdl      (bank_rd[0]),
    .rd_ctx      (bank_rd[1]),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_hdl      (bank_wd[0]),
    .wr_ctx      (bank_wd[1]),
    .done        (done),
    .done_status (done_status),
    .done_slot   (done_slot),
    .done_ctx    (done_ctx)
  );
endmodule

// File: tb/hht_engine_test.sv
module hht_engine_test;
  localparam int HB = 9;
  localparam int N  = 1 << HB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic          req_fmt = 1'b0;
  logic [4:0]    req_chan = '0;
  logic [31:0]   req_handle = '0;
  logic [1:0]    req_engine = '0;
  logic [19:0]   req_inst = '0;
  logic [HB-1:0] req_slot = '0;
  logic          done;
  logic [2:0]    done_status;
  logic [HB-1:0] done_slot;
  logic [31:0]   done_ctx;

  int tests = 0;
  int fails = 0;
  int cyc_total = 0;
  bit finished = 0;

  logic [31:0] sh_hdl [N];
  logic [31:0] sh_ctx [N];

  hht_engine #(.HB(HB)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_fmt(req_fmt), .req_chan(req_chan),
    .req_handle(req_handle), .req_engine(req_engine), .req_inst(req_inst),
    .req_slot(req_slot), .done(done), .done_status(done_status),
    .done_slot(done_slot), .done_ctx(done_ctx)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int hash_m(input longint h, input int ch);
    int acc = 0;
    longint r = h;
    while (r != 0) begin
      acc = acc ^ int'(r % N);
      r = r / N;
    end
    acc = acc ^ (ch * (1 << (HB - 4)));
    return acc % N;
  endfunction

  function automatic logic [31:0] pack_m(input bit fm, input int ch,
                                         input int eng, input int inst);
    longint v;
    if (fm) v = longint'(ch) * (2**23) + eng * (2**20) + inst / 16;
    else    v = 64'h8000_0000 + longint'(ch) * (2**24) + eng * (2**16) + inst / 16;
    return v[31:0];
  endfunction

  function automatic int chan_m(input bit fm, input logic [31:0] w);
    return fm ? int'((w >> 23) % 32) : int'((w >> 24) % 32);
  endfunction

  task automatic do_reset(input string tag);
    int n = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tag, "ready in reset", req_ready, 0);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin
      sh_hdl[i] = '0;
      sh_ctx[i] = '0;
    end
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (req_ready || n > 4*N) break;
    end
    check(tag, "clear cycles", n, N);
  endtask

  // Issue one command and compare against the shadow model.
  task automatic cmd(input string tag, input int op, input bit fm, input int ch,
                     input logic [31:0] h, input int eng, input int inst,
                     input int sl);
    int e_st, e_slot, e_cyc, probes, s, st0, n;
    logic [31:0] e_ctx;
    bit fin;
    e_ctx = '0; probes = 0; e_slot = 0; e_st = 0; fin = 0;
    if (op == 0 || op == 1) begin
      st0 = hash_m(h, ch);
      s = st0;
      while (!fin) begin
        probes++;
        if (sh_hdl[s] == 0 && sh_ctx[s] == 0) begin
          fin = 1;
          if (op == 0) begin
            e_st = 0; e_slot = s;
            sh_hdl[s] = h; sh_ctx[s] = pack_m(fm, ch, eng, inst);
          end else begin
            e_st = 4; e_slot = st0;
          end
        end else if (sh_hdl[s] == h && sh_ctx[s] != 0 && chan_m(fm, sh_ctx[s]) == ch) begin
          fin = 1; e_slot = s;
          if (op == 0) e_st = 1;
          else begin e_st = 3; e_ctx = sh_ctx[s]; end
        end else begin
          s = (s + 1) % N;
          if (s == st0) begin
            fin = 1; e_slot = st0;
            e_st = (op == 0) ? 2 : 4;
          end
        end
      end
      e_cyc = 2 * probes;
    end else if (op == 2) begin
      sh_hdl[sl] = '0; sh_ctx[sl] = '0;
      e_st = 0; e_slot = sl; e_cyc = 1;
    end else begin
      e_st = 5; e_slot = 0; e_cyc = 1;
    end

    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_fmt = fm; req_chan = 5'(ch);
    req_handle = h; req_engine = 2'(eng); req_inst = 20'(inst);
    req_slot = HB'(sl);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, "ready busy (R10)", req_ready, 0);
    n = 0;
    forever begin
      if (n > 0) @(negedge clk);
      if (done || n > 4*N) break;
      @(posedge clk);
      n++;
    end
    check(tag, "status", done_status, e_st);
    check(tag, "slot", done_slot, e_slot);
    check(tag, "ctx", done_ctx, e_ctx);
    check(tag, "cycles (R10)", n, e_cyc);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 150000 && !finished) begin
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_total);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    // R1: clear sweep length and empty table
    do_reset("R1");
    cmd("R1 lookup empty", 1, 0, 0, 32'h0000_0001, 0, 0, 0);
    cmd("R1 lookup empty", 1, 0, 7, 32'hCAFE_F00D, 0, 0, 0);

    // R2 and R3: inserts at the hashed slot, legacy layout
    cmd("R2 R3 insert", 0, 0, 3,  32'hDEAD_BEEF, 1, 20'hABCD0, 0);
    cmd("R2 R3 insert", 0, 0, 17, 32'h1234_5678, 2, 20'h00010, 0);
    cmd("R2 R3 insert", 0, 0, 31, 32'hFFFF_FFFF, 3, 20'hFFFFF, 0);
    cmd("R8 R3 hit",    1, 0, 3,  32'hDEAD_BEEF, 0, 0, 0);
    cmd("R8 R3 hit",    1, 0, 17, 32'h1234_5678, 0, 0, 0);
    cmd("R8 R3 hit",    1, 0, 31, 32'hFFFF_FFFF, 0, 0, 0);

    // R4: compact layout
    cmd("R4 insert", 0, 1, 9, 32'h0BAD_CAFE, 2, 20'h54320, 0);
    cmd("R4 hit",    1, 1, 9, 32'h0BAD_CAFE, 0, 0, 0);

    // R7: duplicate in same channel, allowed in another channel
    cmd("R7 dup",         0, 0, 3, 32'hDEAD_BEEF, 0, 20'h11110, 0);
    cmd("R7 other chan",  0, 0, 4, 32'hDEAD_BEEF, 1, 20'h22220, 0);
    cmd("R8 miss chan",   1, 0, 5, 32'hDEAD_BEEF, 0, 0, 0);

    // R5: collisions and wrap from the last slot
    cmd("R5 collide a", 0, 0, 0, 32'h0000_0007, 1, 20'h00100, 0);
    cmd("R5 collide b", 0, 0, 0, 32'h0000_0206, 1, 20'h00200, 0);
    cmd("R5 collide hit", 1, 0, 0, 32'h0000_0206, 0, 0, 0);
    cmd("R5 last a", 0, 0, 0, 32'h0000_01FF, 1, 20'h00300, 0);
    cmd("R5 wrap b", 0, 0, 0, 32'h0000_03FE, 1, 20'h00400, 0);
    cmd("R5 wrap hit", 1, 0, 0, 32'h0000_03FE, 0, 0, 0);

    // R9: remove then miss, slot reused
    cmd("R9 remove", 2, 0, 0, 32'h0, 0, 0, hash_m(32'h0000_0007, 0));
    cmd("R9 miss after remove", 1, 0, 0, 32'h0000_0007, 0, 0, 0);
    cmd("R9 reuse", 0, 0, 0, 32'h0000_0007, 2, 20'h00500, 0);

    // R11: unused opcode
    cmd("R11 badop", 3, 0, 0, 32'h0000_0007, 0, 0, 5);
    cmd("R11 still hit", 1, 0, 0, 32'h0000_0007, 0, 0, 0);

    // R6: fill every slot, then overflow, then look everything up
    do_reset("R1 second");
    for (int i = 0; i < N; i++)
      cmd("R5 fill", 0, 0, 0, 32'(i), 1, i * 16, 0);
    cmd("R6 full",  0, 0, 0, 32'h0000_0200, 1, 20'h00010, 0);
    cmd("R6 full",  0, 1, 2, 32'hFACE_0000, 3, 20'h00020, 0);
    for (int i = 0; i < N; i++)
      cmd("R8 sweep hit", 1, 0, 0, 32'(i), 0, 0, 0);
    cmd("R8 miss wrap", 1, 0, 0, 32'h0000_0200, 0, 0, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule